// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is a free-running counter with one control register that decides what happens when the count expires. In watchdog mode, expiry raises a reset request for the rest of the system. In interval mode, expiry sets a sticky pending flag and never resets anything. A CPU can then turn that flag into a maskable periodic interrupt. The interrupt needs both the source enable and the global enable, and it is steered to a fixed vector address.

Every control write must carry a key byte in its upper eight bits. A write with a wrong key leaves the register unchanged and raises the reset request at once. Reads return a different constant in the key byte. A read-modify-write that copies the read value back is therefore rejected. The control word also selects one of four expiry periods and carries a self-clearing bit that restarts the count.

Top module: `guard_timer`

## Requirements
- R1: After reset the block is in watchdog mode with the 32768-clock period selected, and `rd_data` reads 0x6900. `flag_pending`, `irq_req` and `rst_req` are low. The counter runs from zero, so `rst_req` rises 32768 clocks after reset is released.
- R2: A write is accepted only when `wr_data[15:8]` equals 0x5A. Any other key leaves the control register unchanged and drives `rst_req` high in the cycle after the write. This includes 0x69, the value that reads return.
- R3: `rd_data` returns 0x69 in bits 15:8, the mode in bit 4 and the period select in bits 1:0. All other bits read zero, including the clear bit 3.
- R4: The period select in bits 1:0 sets the number of clocks between expiries: 3 gives 64, 2 gives 512, 1 gives 8192 and 0 gives 32768. The count is measured from a write that sets the clear bit.
- R5: A keyed write with bit 3 set restarts the count from zero. An expiry that would have landed on the same clock edge is dropped.
- R6: With bit 4 at 0 (watchdog mode), expiry drives `rst_req` high for exactly one clock and leaves `flag_pending` untouched.
- R7: With bit 4 at 1 (interval mode), expiry sets `flag_pending` and does not raise `rst_req`.
- R8: `flag_pending` stays set until `flag_clr` or `irq_ack` is high at a clock edge. If a new expiry happens at the same edge as a clear, the flag stays set.
- R9: `irq_req` is high only while `flag_pending`, `irq_en` and `glb_en` are all high.
- R10: `vec_addr` reads 0xFFF4 while `irq_req` is high and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Write word: key byte, mode, clear, period select |
| rd_data | output | 16 | Control register read value |
| irq_en | input | 1 | Source enable for the interval interrupt |
| glb_en | input | 1 | Global interrupt enable |
| flag_clr | input | 1 | Clears the pending flag |
| irq_ack | input | 1 | Interrupt acknowledge, also clears the flag |
| flag_pending | output | 1 | Sticky interval-expiry flag |
| irq_req | output | 1 | Gated interrupt request |
| vec_addr | output | 16 | Interrupt vector address while requesting |
| rst_req | output | 1 | System reset request |

## Verification
The bench checks every period select in both modes, sampling one cycle before and at the expected expiry. A counter that is off by one in its limit or in its restart shows up there as an early or late event. Writing back the read value tests that a key comparison against the read constant, or no key check at all, fails to raise a reset. A clear write timed to land exactly on an expiry catches a design that fires a spurious flag. A flag clear at the same edge as a new expiry catches a design that drops the event. All four enable combinations are tried, so an interrupt gated by only one enable is caught.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
    localparam int KEY_HI   = 15;
    localparam int KEY_LO   = 8;
    localparam int MODE_BIT = 4;
    localparam int CLR_BIT  = 3;
    localparam int SEL_HI   = 1;
    localparam int SEL_LO   = 0;

    typedef struct packed {
        logic       interval;
        logic [1:0] sel;
    } ctrl_t;
endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
    import guard_timer_pkg::*;
#(
    parameter logic [7:0] KEY_WR = 8'h5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output ctrl_t       ctrl,
    output logic        clr_pulse,
    output logic        key_bad
);
    typedef struct packed {
        ctrl_t ctrl;
    } st_t;

    st_t  st_d, st_q;
    logic key_ok;
    logic unused_bits;

    assign unused_bits = ^{wr_data[7:5], wr_data[2]};

    always_comb begin
        st_d      = st_q;
        key_ok    = (wr_data[KEY_HI:KEY_LO] == KEY_WR);
        clr_pulse = wr_en && key_ok && wr_data[CLR_BIT];
        key_bad   = wr_en && !key_ok;
        if (wr_en && key_ok) begin
            st_d.ctrl.interval = wr_data[MODE_BIT];
            st_d.ctrl.sel      = wr_data[SEL_HI:SEL_LO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = st_q.ctrl;
endmodule

// File: rtl/guard_count.sv
module guard_count #(
    parameter int TAP0  = 32768,
    parameter int TAP1  = 8192,
    parameter int TAP2  = 512,
    parameter int TAP3  = 64,
    parameter int CNT_W = $clog2(TAP0)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST0 = CNT_W'(TAP0 - 1);
    localparam logic [CNT_W-1:0] LAST1 = CNT_W'(TAP1 - 1);
    localparam logic [CNT_W-1:0] LAST2 = CNT_W'(TAP2 - 1);
    localparam logic [CNT_W-1:0] LAST3 = CNT_W'(TAP3 - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        case (sel)
            2'd0:    last = LAST0;
            2'd1:    last = LAST1;
            2'd2:    last = LAST2;
            default: last = LAST3;
        endcase
        expire = (st_q.cnt >= last) && !clr;
        st_d   = st_q;
        if (clr || expire) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/guard_flag.sv
module guard_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic interval,
    input  logic key_bad,
    input  logic flag_clr,
    input  logic irq_ack,
    output logic flag,
    output logic rst_req
);
    typedef struct packed {
        logic flag;
        logic rst_req;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (expire && interval) begin
            st_d.flag = 1'b1;
        end else if (flag_clr || irq_ack) begin
            st_d.flag = 1'b0;
        end
        st_d.rst_req = (expire && !interval) || key_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag    = st_q.flag;
    assign rst_req = st_q.rst_req;
endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_timer_pkg::*;
#(
    parameter logic [7:0]  KEY_WR   = 8'h5A,
    parameter logic [7:0]  KEY_RD   = 8'h69,
    parameter logic [15:0] VEC_ADDR = 16'hFFF4,
    parameter int          TAP0     = 32768,
    parameter int          TAP1     = 8192,
    parameter int          TAP2     = 512,
    parameter int          TAP3     = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        irq_en,
    input  logic        glb_en,
    input  logic        flag_clr,
    input  logic        irq_ack,
    output logic        flag_pending,
    output logic        irq_req,
    output logic [15:0] vec_addr,
    output logic        rst_req
);
    localparam int CNT_W = $clog2(TAP0);

    ctrl_t            ctrl;
    logic             clr_pulse;
    logic             key_bad;
    logic             expire;
    logic [CNT_W-1:0] cnt;
    logic             mode_interval;

    guard_ctrl #(.KEY_WR(KEY_WR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ctrl      (ctrl),
        .clr_pulse (clr_pulse),
        .key_bad   (key_bad)
    );

    guard_count #(
        .TAP0 (TAP0), .TAP1 (TAP1), .TAP2 (TAP2), .TAP3 (TAP3), .CNT_W (CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (ctrl.sel),
        .clr    (clr_pulse),
        .cnt    (cnt),
        .expire (expire)
    );

    assign mode_interval = ctrl.interval;

    guard_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .interval (mode_interval),
        .key_bad  (key_bad),
        .flag_clr (flag_clr),
        .irq_ack  (irq_ack),
        .flag     (flag_pending),
        .rst_req  (rst_req)
    );

    always_comb begin
        rd_data                  = '0;
        rd_data[KEY_HI:KEY_LO]   = KEY_RD;
        rd_data[MODE_BIT]        = ctrl.interval;
        rd_data[SEL_HI:SEL_LO]   = ctrl.sel;
    end

    assign irq_req  = flag_pending && irq_en && glb_en;
    assign vec_addr = irq_req ? VEC_ADDR : 16'h0000;
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
    parameter logic [7:0]  KEY_WR   = 8'h5A,
    parameter logic [7:0]  KEY_RD   = 8'h69,
    parameter logic [15:0] VEC_ADDR = 16'hFFF4,
    parameter int          CNT_W    = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [15:0]      wr_data,
    input logic [15:0]      rd_data,
    input logic             irq_en,
    input logic             glb_en,
    input logic             flag_clr,
    input logic             irq_ack,
    input logic             flag_pending,
    input logic             irq_req,
    input logic [15:0]      vec_addr,
    input logic             rst_req,
    input logic             expire,
    input logic             mode_interval,
    input logic [CNT_W-1:0] cnt
);
    assert_key_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[15:8] != KEY_WR) |=> (rst_req && $stable(rd_data)));

    assert_read_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15:8] == KEY_RD && rd_data[7:5] == 3'b000 && rd_data[3:2] == 2'b00));

    assert_clear_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[15:8] == KEY_WR && wr_data[3]) |=> (cnt == '0));

    assert_wd_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !mode_interval) |=> rst_req);

    assert_irq_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && mode_interval) |=> flag_pending);

    assert_no_reset_interval_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && mode_interval && !(wr_en && wr_data[15:8] != KEY_WR)) |=> !rst_req);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_pending && !flag_clr && !irq_ack) |=> flag_pending);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> flag_pending);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !glb_en) |-> !irq_req);

    assert_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (vec_addr == VEC_ADDR));
endmodule

bind guard_timer guard_timer_chk #(
    .KEY_WR (KEY_WR), .KEY_RD (KEY_RD), .VEC_ADDR (VEC_ADDR), .CNT_W (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .irq_en        (irq_en),
    .glb_en        (glb_en),
    .flag_clr      (flag_clr),
    .irq_ack       (irq_ack),
    .flag_pending  (flag_pending),
    .irq_req       (irq_req),
    .vec_addr      (vec_addr),
    .rst_req       (rst_req),
    .expire        (expire),
    .mode_interval (mode_interval),
    .cnt           (cnt)
);

// File: tb/guard_timer_bench.sv
module guard_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCH_CYC  = 190000;
    localparam int TBL_N      = 6;
    localparam int T_MODE [TBL_N] = '{1, 0, 1, 0, 1, 1};
    localparam int T_SEL  [TBL_N] = '{0, 2, 2, 3, 1, 3};
    localparam int T_PER  [TBL_N] = '{32768, 512, 512, 64, 8192, 64};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        irq_en;
    logic        glb_en;
    logic        flag_clr;
    logic        irq_ack;
    logic        flag_pending;
    logic        irq_req;
    logic [15:0] vec_addr;
    logic        rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    guard_timer u_guard_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .irq_en       (irq_en),
        .glb_en       (glb_en),
        .flag_clr     (flag_clr),
        .irq_ack      (irq_ack),
        .flag_pending (flag_pending),
        .irq_req      (irq_req),
        .vec_addr     (vec_addr),
        .rst_req      (rst_req)
    );

    function automatic logic [15:0] mk(input logic [7:0] key, input logic md,
                                       input logic clr, input logic [1:0] sel);
        return {key, 3'b000, md, clr, 1'b0, sel};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        irq_en = 1'b0; glb_en = 1'b0; flag_clr = 1'b0; irq_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset read", {16'h0, rd_data}, 32'h6900);
        chk("R1 reset flag", {31'h0, flag_pending}, 0);
        chk("R1 reset rst_req", {31'h0, rst_req}, 0);
        chk("R1 reset irq_req", {31'h0, irq_req}, 0);
        rst_n = 1'b1;
        repeat (32767) @(negedge clk);
        chk("R1 no early watchdog reset", {31'h0, rst_req}, 0);
        @(negedge clk);
        chk("R1 watchdog reset at 32768", {31'h0, rst_req}, 1);
        chk("R6 flag untouched", {31'h0, flag_pending}, 0);
        @(negedge clk);
        chk("R6 reset one clock", {31'h0, rst_req}, 0);

        for (int i = 0; i < TBL_N; i++) begin
            flag_clr = 1'b1;
            do_write(mk(8'h5A, T_MODE[i][0], 1'b1, T_SEL[i][1:0]));
            flag_clr = 1'b0;
            chk("R3 R2 read back", {16'h0, rd_data},
                {16'h0, mk(8'h69, T_MODE[i][0], 1'b0, T_SEL[i][1:0])});
            repeat (T_PER[i] - 1) @(negedge clk);
            chk("R4 no early flag", {31'h0, flag_pending}, 0);
            chk("R4 no early reset", {31'h0, rst_req}, 0);
            @(negedge clk);
            if (T_MODE[i] == 1) begin
                chk("R7 R4 flag at period", {31'h0, flag_pending}, 1);
                chk("R7 no reset", {31'h0, rst_req}, 0);
            end else begin
                chk("R6 R4 reset at period", {31'h0, rst_req}, 1);
                chk("R6 no flag", {31'h0, flag_pending}, 0);
            end
            @(negedge clk);
            chk("R6 reset pulse ends", {31'h0, rst_req}, 0);
        end

        repeat (10) @(negedge clk);
        chk("R8 flag sticky", {31'h0, flag_pending}, 1);
        irq_en = 1'b0; glb_en = 1'b0; @(negedge clk);
        chk("R9 both off", {31'h0, irq_req}, 0);
        irq_en = 1'b1; glb_en = 1'b0; @(negedge clk);
        chk("R9 global off", {31'h0, irq_req}, 0);
        chk("R10 no vector", {16'h0, vec_addr}, 0);
        irq_en = 1'b0; glb_en = 1'b1; @(negedge clk);
        chk("R9 source off", {31'h0, irq_req}, 0);
        irq_en = 1'b1; glb_en = 1'b1; @(negedge clk);
        chk("R9 both on", {31'h0, irq_req}, 1);
        chk("R10 vector", {16'h0, vec_addr}, 32'hFFF4);
        irq_en = 1'b0; glb_en = 1'b0;

        do_write(mk(8'h5A, 1'b1, 1'b1, 2'd3));
        chk("R8 write keeps flag", {31'h0, flag_pending}, 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R8 flag_clr clears", {31'h0, flag_pending}, 0);
        repeat (62) @(negedge clk);
        chk("R4 quiet before expiry", {31'h0, flag_pending}, 0);
        @(negedge clk);
        chk("R7 flag after restart", {31'h0, flag_pending}, 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R8 ack clears", {31'h0, flag_pending}, 0);
        repeat (62) @(negedge clk);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R8 expiry wins over clear", {31'h0, flag_pending}, 1);

        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R8 cleared again", {31'h0, flag_pending}, 0);
        repeat (62) @(negedge clk);
        do_write(mk(8'h5A, 1'b1, 1'b1, 2'd3));
        chk("R5 expiry dropped by clear", {31'h0, flag_pending}, 0);
        repeat (63) @(negedge clk);
        chk("R5 restart no early flag", {31'h0, flag_pending}, 0);
        @(negedge clk);
        chk("R5 restart period", {31'h0, flag_pending}, 1);

        do_write(mk(8'h33, 1'b0, 1'b0, 2'd0));
        chk("R2 bad key reset", {31'h0, rst_req}, 1);
        chk("R2 bad key no update", {16'h0, rd_data}, {16'h0, mk(8'h69, 1'b1, 1'b0, 2'd3)});
        @(negedge clk);
        chk("R2 reset one clock", {31'h0, rst_req}, 0);
        do_write(rd_data | 16'h0008);
        chk("R2 read-back key rejected", {31'h0, rst_req}, 1);
        @(negedge clk);

        rst_n = 1'b0; #1;
        chk("R1 reset read again", {16'h0, rd_data}, 32'h6900);
        chk("R1 reset clears flag", {31'h0, flag_pending}, 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCH_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule